// File: doc/BRIEF.md
# Queued Multicore Hardware Semaphore

This block guards one shared resource for a set of processor cores. A core asks for the resource in one of two ways. In a direct query it strobes a request and then reads its bit of the owner vector. If the bit is not set, the core queries again. In a queued query it strobes a request once. The unit then keeps that request in a first-come-first-served queue and raises a level interrupt to that core when the resource is handed over.

The current owner gives the resource back with a release strobe. On that release, ownership moves to the oldest queued core in the next cycle. If nothing is queued, the semaphore becomes free. Requests that arrive in the same cycle are ordered by core index, lowest first. The query logic is a single registered decision per cycle, so two cores can never both own the resource.

Top module: `qsem_unit`

## Requirements
- R1: After reset, `owner_o`, `waiting_o` and `irq_o` are all zero and `err_o` is low.
- R2: A direct query from core i while the semaphore is free sets bit i of `owner_o` on the next clock edge. A direct query while it is owned changes neither `owner_o` nor `waiting_o`, and no request is kept.
- R3: When several eligible cores query a free semaphore in one cycle, only the lowest-indexed one becomes owner, and `owner_o` never has more than one bit set.
- R4: A queued query from a core that neither owns the resource nor already waits, made while the resource is owned, sets that core's bit of `waiting_o` on the next edge. Queued cores are served strictly in arrival order, and same-cycle arrivals enter in ascending core index.
- R5: A release from the owner moves ownership to the queue head on the next edge and removes the head from `waiting_o`. With an empty queue, the release leaves `owner_o` all zero. A query arriving in that same cycle is then judged against a free semaphore.
- R6: Bit i of `irq_o` is a level that rises when core i gains the resource through a queued query, whether granted at once or taken from the queue. It falls on `irq_ack_i[i]` or on a release by core i. It is never set for a core that does not own the resource.
- R7: A release from a core that does not own the semaphore leaves `owner_o` and `waiting_o` unchanged, and it sets `err_o`, which stays high until reset.
- R8: A queued query from a core already in the queue is dropped: `waiting_o` and the later grant order stay as they were. Requests from the current owner are also ignored.
- R9: `waiting_o` never includes the owner and never has more than NUM_CORES-1 bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_req_i | input | NUM_CORES | Per-core direct query strobe |
| queue_req_i | input | NUM_CORES | Per-core queued query strobe |
| release_i | input | NUM_CORES | Per-core release strobe |
| irq_ack_i | input | NUM_CORES | Per-core interrupt acknowledge |
| owner_o | output | NUM_CORES | One-hot owner vector, all zero when free |
| waiting_o | output | NUM_CORES | Cores currently held in the queue |
| irq_o | output | NUM_CORES | Per-core grant interrupt, level |
| err_o | output | 1 | Sticky flag for a release by a non-owner |

## Verification
Every result of the block is registered, and a strobe sampled at a rising edge shows up on the outputs right after that same edge. This holds for a grant, an enqueue, a hand-off, an interrupt change and the error flag. The bench therefore drives strobes on the falling edge and compares all four outputs one time step after the next rising edge. Before that edge, it advances its own reference state by one step. Queue order is never read directly: it is checked through the sequence of owners that successive releases produce.

// File: rtl/qsem_pick.sv
module qsem_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] oh_o
);
  // lowest index wins
  always_comb begin
    oh_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) oh_o = N'(1) << i;
    end
  end
endmodule

// File: rtl/qsem_fifo.sv
module qsem_fifo #(
  parameter int N = 4,
  localparam int IW = $clog2(N),
  localparam int DEPTH = N - 1,
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  push_i,
  input  logic          pop_i,
  output logic          head_vld_o,
  output logic [IW-1:0] head_idx_o,
  output logic [N-1:0]  queued_o
);
  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

  logic [IW-1:0] ent_q [DEPTH];
  logic [IW-1:0] ent_d [DEPTH];
  logic [PW-1:0] cnt_q, cnt_d;
  logic [N-1:0]  mask_q, mask_d;

  always_comb begin
    ent_d  = ent_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    if (pop_i && cnt_q != '0) begin
      mask_d[ent_q[0]] = 1'b0;
      for (int k = 0; k < DEPTH - 1; k++) ent_d[k] = ent_q[k+1];
      cnt_d = cnt_q - PW'(1);
    end
    // same-cycle pushes land in ascending core order
    for (int c = 0; c < N; c++) begin
      if (push_i[c] && !mask_d[c] && cnt_d < DEPTH_W) begin
        ent_d[cnt_d[QW-1:0]] = IW'(c);
        mask_d[c] = 1'b1;
        cnt_d = cnt_d + PW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mask_q <= '0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      ent_q  <= ent_d;
    end
  end

  assign head_vld_o = (cnt_q != '0);
  assign head_idx_o = ent_q[0];
  assign queued_o   = mask_q;
endmodule

// File: rtl/qsem_unit.sv
module qsem_unit #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] direct_req_i,
  input  logic [NUM_CORES-1:0] queue_req_i,
  input  logic [NUM_CORES-1:0] release_i,
  input  logic [NUM_CORES-1:0] irq_ack_i,
  output logic [NUM_CORES-1:0] owner_o,
  output logic [NUM_CORES-1:0] waiting_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic                 err_o
);
  localparam int N  = NUM_CORES;
  localparam int IW = $clog2(N);

  logic [N-1:0]  owner_q, owner_d, irq_q, irq_d;
  logic [N-1:0]  queued, elig, cand, win_oh, push, head_oh, grant_irq;
  logic          err_q, rel_ok, bad_rel, free_now, pop, head_vld;
  logic [IW-1:0] head_idx;

  assign rel_ok   = |(release_i & owner_q);
  assign bad_rel  = |(release_i & ~owner_q);
  // free at cycle start, or emptied by a release with nobody waiting
  assign free_now = ~|owner_q | (rel_ok & ~head_vld);
  assign pop      = rel_ok & head_vld;
  assign elig     = (direct_req_i | queue_req_i) & ~owner_q & ~queued;
  assign cand     = free_now ? elig : '0;

  qsem_pick #(.N(N)) u_pick (
    .req_i (cand),
    .oh_o  (win_oh)
  );

  assign push = queue_req_i & ~owner_q & ~queued & ~win_oh;

  qsem_fifo #(.N(N)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .head_vld_o (head_vld),
    .head_idx_o (head_idx),
    .queued_o   (queued)
  );

  always_comb begin
    head_oh = '0;
    head_oh[head_idx] = 1'b1;
  end

  always_comb begin
    if (pop) begin
      owner_d   = head_oh;
      grant_irq = head_oh;
    end else if (free_now) begin
      owner_d   = win_oh;
      grant_irq = win_oh & queue_req_i;
    end else begin
      owner_d   = owner_q;
      grant_irq = '0;
    end
    irq_d = grant_irq | (irq_q & ~irq_ack_i & ~(release_i & owner_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      irq_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      owner_q <= owner_d;
      irq_q   <= irq_d;
      err_q   <= err_q | bad_rel;
    end
  end

  assign owner_o   = owner_q;
  assign waiting_o = queued;
  assign irq_o     = irq_q;
  assign err_o     = err_q;
endmodule

// File: rtl/qsem_chk.sv
module qsem_chk #(
  parameter int N = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] direct_req_i,
  input logic [N-1:0] queue_req_i,
  input logic [N-1:0] release_i,
  input logic [N-1:0] owner_o,
  input logic [N-1:0] waiting_o,
  input logic [N-1:0] irq_o,
  input logic         err_o
);
  a_r2_direct_free_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == '0 && |direct_req_i) |=> (owner_o != '0));

  a_r3_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_o));

  a_r5_handoff_from_queue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(release_i & owner_o) && |waiting_o) |=> |(owner_o & $past(waiting_o)));

  a_r5_release_to_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(release_i & owner_o) && waiting_o == '0 && direct_req_i == '0 && queue_req_i == '0)
    |=> (owner_o == '0));

  a_r6_irq_only_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~owner_o) == '0);

  a_r7_bad_release_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(release_i & ~owner_o) |=> err_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r9_owner_not_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o & owner_o) == '0);

  a_r9_queue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(waiting_o) <= N - 1);
endmodule

bind qsem_unit qsem_chk #(.N(NUM_CORES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .direct_req_i (direct_req_i),
  .queue_req_i  (queue_req_i),
  .release_i    (release_i),
  .owner_o      (owner_o),
  .waiting_o    (waiting_o),
  .irq_o        (irq_o),
  .err_o        (err_o)
);

// File: tb/qsem_unit_tb_top.sv
module qsem_unit_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] dir_r = '0, que_r = '0, rel_r = '0, ack_r = '0;
  logic [N-1:0] owner_o, waiting_o, irq_o;
  logic         err_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  int m_own;
  int m_q [N];
  int m_n;
  logic [N-1:0] m_irq;
  logic m_err;

  always #5 clk = ~clk;

  qsem_unit #(.NUM_CORES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .direct_req_i(dir_r), .queue_req_i(que_r),
    .release_i(rel_r), .irq_ack_i(ack_r),
    .owner_o(owner_o), .waiting_o(waiting_o),
    .irq_o(irq_o), .err_o(err_o)
  );

  function automatic logic [N-1:0] own_vec();
    logic [N-1:0] v = '0;
    if (m_own >= 0) v[m_own] = 1'b1;
    return v;
  endfunction

  function automatic logic [N-1:0] wait_vec();
    logic [N-1:0] v = '0;
    for (int k = 0; k < m_n; k++) v[m_q[k]] = 1'b1;
    return v;
  endfunction

  task automatic model_reset();
    m_own = -1; m_n = 0; m_irq = '0; m_err = 1'b0;
  endtask

  task automatic model_step(input logic [N-1:0] d, q, r, a);
    logic [N-1:0] pend = wait_vec();
    int  old = m_own;
    int  win = -1;
    bit  rel_ok, freed;
    for (int c = 0; c < N; c++) if (r[c] && c != old) m_err = 1'b1;
    rel_ok = (old >= 0) && r[old];
    m_irq = m_irq & ~a;
    if (rel_ok) m_irq[old] = 1'b0;
    freed = (old < 0) || (rel_ok && m_n == 0);
    if (rel_ok && m_n > 0) begin
      m_own = m_q[0];
      for (int k = 0; k < N - 1; k++) m_q[k] = m_q[k+1];
      m_n--;
      m_irq[m_own] = 1'b1;
    end else if (freed) begin
      m_own = -1;
      for (int c = 0; c < N; c++) begin
        if (m_own < 0 && (d[c] || q[c]) && c != old && !pend[c]) begin
          m_own = c;
          win = c;
          if (q[c]) m_irq[c] = 1'b1;
        end
      end
    end
    for (int c = 0; c < N; c++) begin
      if (q[c] && c != old && !pend[c] && c != win) begin
        m_q[m_n] = c;
        m_n++;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "owner",   32'(owner_o),   32'(own_vec()));
    chk(tag, "waiting", 32'(waiting_o), 32'(wait_vec()));
    chk(tag, "irq",     32'(irq_o),     32'(m_irq));
    chk(tag, "err",     32'(err_o),     32'(m_err));
  endtask

  task automatic cyc(input string tag, input logic [N-1:0] d, q, r, a);
    @(negedge clk);
    dir_r = d; que_r = q; rel_r = r; ack_r = a;
    model_step(d, q, r, a);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    dir_r = '0; que_r = '0; rel_r = '0; ack_r = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    compare("R1");
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();                                   // R1
    cyc("R2", 4'b0010, 4'b0000, 4'b0000, 4'b0000); // core1 takes free sem
    cyc("R2", 4'b0100, 4'b0000, 4'b0000, 4'b0000); // direct on busy: no effect
    cyc("R4", 4'b0000, 4'b1001, 4'b0000, 4'b0000); // cores 0,3 queue, 0 first
    cyc("R8", 4'b0000, 4'b0011, 4'b0000, 4'b0000); // dup from 0 and owner 1 dropped
    cyc("R7", 4'b0000, 4'b0000, 4'b0100, 4'b0000); // non-owner release
    cyc("R5", 4'b0000, 4'b0000, 4'b0010, 4'b0000); // hand-off to core0
    cyc("R6", 4'b0000, 4'b0000, 4'b0000, 4'b0001); // ack clears irq0
    cyc("R5", 4'b0000, 4'b0000, 4'b0001, 4'b0000); // hand-off to core3
    cyc("R6", 4'b0000, 4'b0000, 4'b1000, 4'b0000); // release clears irq3, free
    cyc("R3", 4'b0110, 4'b0000, 4'b0000, 4'b0000); // 1 beats 2
    cyc("R4", 4'b0000, 4'b1100, 4'b0000, 4'b0000); // 2,3 queue in index order
    cyc("R4", 4'b0000, 4'b0001, 4'b0000, 4'b0000); // 0 queued behind
    cyc("R9", 4'b0000, 4'b0000, 4'b0010, 4'b0000); // core2 owns, 3,0 wait
    cyc("R5", 4'b0000, 4'b0000, 4'b0100, 4'b0000); // core3
    cyc("R5", 4'b0000, 4'b0000, 4'b1000, 4'b0000); // core0
    cyc("R5", 4'b0000, 4'b1000, 4'b0001, 4'b0000); // release+new req: 3 gets it
    cyc("R6", 4'b0000, 4'b0000, 4'b0000, 4'b0000);

    do_reset();
    for (int t = 0; t < 3000; t++) begin
      logic [N-1:0] d, q, r, a;
      for (int c = 0; c < N; c++) begin
        d[c] = ($urandom % 8) == 0;
        q[c] = ($urandom % 5) == 0;
        a[c] = m_irq[c] && (($urandom % 3) == 0);
        r[c] = 1'b0;
      end
      if (m_own >= 0 && ($urandom % 3) == 0) r[m_own] = 1'b1;
      if (($urandom % 40) == 0) r[$urandom % N] = 1'b1;
      cyc("R3", d, q, r, a);
    end
    cyc("R9", '0, '0, '0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule